// File: doc/BRIEF.md
# Integer Decode and Execute Slice

This block is the combinational heart of a small integer core. In one pass it takes a 32-bit instruction word and the two source operands that the register file returned for it. It splits the word into its register indices and produces the value to write back, along with a write strobe for the destination register. It handles register-register add, subtract, OR, XOR and the three shift kinds; add, AND and OR against an immediate; and an upper-immediate load. Any other encoding is reported as illegal and suppresses the write.

The immediate rules are deliberately nonstandard, and surrounding logic must match them exactly. The add-immediate form sign-extends its 12-bit constant. The AND-immediate and OR-immediate forms zero-extend it. The upper-immediate load places its 20-bit field 16 bits up, so the top four bits of the field are lost. A parameter selects between two shifter implementations. Both produce the same results.

Top module: `isa_lite_exec`

## Requirements
- R1: `rs1_idx` always equals instruction bits [19:15], `rs2_idx` bits [24:20] and `rd_idx` bits [11:7], whatever the opcode.
- R2: With opcode 0110011 and funct3 000 (bits [14:12]), funct7 (bits [31:25]) 0000000 yields rs1+rs2 and 0100000 yields rs1-rs2, both modulo 2^32.
- R3: With opcode 0110011 and funct7 0000000, funct3 110 yields rs1 OR rs2 and funct3 100 yields rs1 XOR rs2.
- R4: With opcode 0110011, funct3 001 and funct7 0000000, the result is rs1 shifted left by rs2[4:0]; rs2 bits [31:5] have no effect.
- R5: With opcode 0110011 and funct3 101, funct7 0000000 shifts rs1 right by rs2[4:0] with zero fill, and funct7 0100000 does the same with copies of rs1 bit 31.
- R6: With opcode 0010011 and funct3 000, the result is rs1 plus bits [31:20] sign-extended to 32 bits. Bits [31:25] act as immediate bits here, not as funct7.
- R7: With opcode 0010011, funct3 111 yields rs1 AND, and funct3 110 yields rs1 OR, with bits [31:20] zero-extended to 32 bits.
- R8: Opcode 0110111 yields bits [31:12] shifted left by 16 within 32 bits, so the result is {instr[27:12], 16'h0000}. Neither operand affects it.
- R9: Every other combination of opcode, funct3 and funct7 raises `illegal`, drives `rd_we` low and drives `rd_data` to zero. That includes funct7 values other than the two listed, and 0100000 with any funct3 other than 000 or 101.
- R10: `rd_we` is high exactly when the instruction is legal and `rd_idx` is nonzero. With `rd_idx` zero, `rd_data` still carries the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | First source operand |
| rs2_val | input | 32 | Second source operand |
| rs1_idx | output | 5 | First source register index |
| rs2_idx | output | 5 | Second source register index |
| rd_idx | output | 5 | Destination register index |
| rd_we | output | 1 | Destination write strobe |
| rd_data | output | 32 | Write-back value |
| illegal | output | 1 | Unsupported encoding |

## Verification
The in-line assertions watch every evaluation for the invariants that link the pieces. Illegal and zero-destination instructions never write, and an illegal result is forced to zero. An add result minus its second operand gives back the first operand. Zero-fill and sign-fill right shifts agree whenever the operand's sign bit is clear. Only the bench's sweeps can show that each encoding maps to the right operation. They also show the exact extension of each immediate, the loss of the top upper-immediate bits, that the high bits of the shift amount are ignored, and that the full space of opcode, funct3 and funct7 is classified correctly.

// File: rtl/isa_lite_pkg.sv
package isa_lite_pkg;
   localparam logic [6:0] OPC_REG   = 7'b0110011;
   localparam logic [6:0] OPC_IMM   = 7'b0010011;
   localparam logic [6:0] OPC_UPPER = 7'b0110111;

   localparam logic [2:0] F3_ADDSUB = 3'b000;
   localparam logic [2:0] F3_SLL    = 3'b001;
   localparam logic [2:0] F3_XOR    = 3'b100;
   localparam logic [2:0] F3_SHR    = 3'b101;
   localparam logic [2:0] F3_OR     = 3'b110;
   localparam logic [2:0] F3_AND    = 3'b111;

   localparam logic [6:0] F7_BASE = 7'b0000000;
   localparam logic [6:0] F7_ALT  = 7'b0100000;

   typedef enum logic [3:0] {
      FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR,
      FN_SLL, FN_SRL, FN_SRA, FN_PASSB
   } alu_fn_e;

   typedef enum logic [1:0] {
      OPB_REG, OPB_SEXT, OPB_ZEXT, OPB_UPPER
   } opb_sel_e;
endpackage

// File: rtl/ilx_fields.sv
module ilx_fields #(
   parameter int XLEN        = 32,
   parameter int RIDX_W      = 5,
   parameter int UPPER_SHIFT = 16
) (
   input  logic [31:0]       instr,
   output logic [RIDX_W-1:0] rs1_idx,
   output logic [RIDX_W-1:0] rs2_idx,
   output logic [RIDX_W-1:0] rd_idx,
   output logic [6:0]        opcode,
   output logic [2:0]        funct3,
   output logic [6:0]        funct7,
   output logic [XLEN-1:0]   imm_sext,
   output logic [XLEN-1:0]   imm_zext,
   output logic [XLEN-1:0]   imm_upper
);
   localparam int IMM_W = 12;
   localparam int UPW   = 20;

   assign opcode  = instr[6:0];
   assign rd_idx  = instr[11:7];
   assign funct3  = instr[14:12];
   assign rs1_idx = instr[19:15];
   assign rs2_idx = instr[24:20];
   assign funct7  = instr[31:25];

   assign imm_sext  = {{(XLEN-IMM_W){instr[31]}}, instr[31:20]};
   assign imm_zext  = {{(XLEN-IMM_W){1'b0}}, instr[31:20]};
   assign imm_upper = {{(XLEN-UPW){1'b0}}, instr[31:12]} << UPPER_SHIFT;
endmodule

// File: rtl/ilx_decode.sv
module ilx_decode
   import isa_lite_pkg::*;
(
   input  logic [6:0] opcode,
   input  logic [2:0] funct3,
   input  logic [6:0] funct7,
   output alu_fn_e    fn,
   output opb_sel_e   opb,
   output logic       legal
);
   always_comb begin
      fn    = FN_ADD;
      opb   = OPB_REG;
      legal = 1'b0;
      case (opcode)
         OPC_REG: begin
            case (funct3)
               F3_ADDSUB: begin
                  if (funct7 == F7_BASE)     begin fn = FN_ADD; legal = 1'b1; end
                  else if (funct7 == F7_ALT) begin fn = FN_SUB; legal = 1'b1; end
               end
               F3_SHR: begin
                  if (funct7 == F7_BASE)     begin fn = FN_SRL; legal = 1'b1; end
                  else if (funct7 == F7_ALT) begin fn = FN_SRA; legal = 1'b1; end
               end
               F3_OR:  if (funct7 == F7_BASE) begin fn = FN_OR;  legal = 1'b1; end
               F3_XOR: if (funct7 == F7_BASE) begin fn = FN_XOR; legal = 1'b1; end
               F3_SLL: if (funct7 == F7_BASE) begin fn = FN_SLL; legal = 1'b1; end
               default: legal = 1'b0;
            endcase
         end
         OPC_IMM: begin
            case (funct3)
               F3_ADDSUB: begin fn = FN_ADD; opb = OPB_SEXT; legal = 1'b1; end
               F3_AND:    begin fn = FN_AND; opb = OPB_ZEXT; legal = 1'b1; end
               F3_OR:     begin fn = FN_OR;  opb = OPB_ZEXT; legal = 1'b1; end
               default:   legal = 1'b0;
            endcase
         end
         OPC_UPPER: begin fn = FN_PASSB; opb = OPB_UPPER; legal = 1'b1; end
         default: legal = 1'b0;
      endcase
   end

   always_comb begin
      if (legal && opcode == OPC_REG)
         AST_REG_F7_KNOWN: assert (funct7 == F7_BASE || funct7 == F7_ALT)
            else $error("register op accepted with unknown funct7"); // R9
   end
endmodule

// File: rtl/ilx_alu.sv
module ilx_alu
   import isa_lite_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int SHIFT_STYLE = 1
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_fn_e         fn,
   output logic [XLEN-1:0] y
);
   localparam int SHW = $clog2(XLEN);

   logic [SHW-1:0]  shamt;
   logic [XLEN-1:0] sll_y, srl_y, sra_y;

   assign shamt = b[SHW-1:0];

   generate
      if (SHIFT_STYLE == 0) begin : g_opshift
         assign sll_y = a << shamt;
         assign srl_y = a >> shamt;
         assign sra_y = $signed(a) >>> shamt;
      end else begin : g_staged
         logic [XLEN-1:0] ls [SHW+1];
         logic [XLEN-1:0] rs [SHW+1];
         logic [XLEN-1:0] as [SHW+1];
         assign ls[0] = a;
         assign rs[0] = a;
         assign as[0] = a;
         for (genvar s = 0; s < SHW; s++) begin : g_stage
            localparam int D = 1 << s;
            assign ls[s+1] = shamt[s] ? {ls[s][XLEN-1-D:0], {D{1'b0}}} : ls[s];
            assign rs[s+1] = shamt[s] ? {{D{1'b0}}, rs[s][XLEN-1:D]} : rs[s];
            assign as[s+1] = shamt[s] ? {{D{a[XLEN-1]}}, as[s][XLEN-1:D]} : as[s];
         end
         assign sll_y = ls[SHW];
         assign srl_y = rs[SHW];
         assign sra_y = as[SHW];
      end
   endgenerate

   always_comb begin
      case (fn)
         FN_ADD:   y = a + b;
         FN_SUB:   y = a - b;
         FN_AND:   y = a & b;
         FN_OR:    y = a | b;
         FN_XOR:   y = a ^ b;
         FN_SLL:   y = sll_y;
         FN_SRL:   y = srl_y;
         FN_SRA:   y = sra_y;
         FN_PASSB: y = b;
         default:  y = '0;
      endcase
   end

   always_comb begin
      if (!a[XLEN-1])
         AST_SHR_FILL_AGREE: assert (sra_y == srl_y)
            else $error("right shifts disagree on non-negative operand"); // R5
      if (fn == FN_ADD)
         AST_ADD_INVERTS: assert ((y - b) == a)
            else $error("sum minus addend does not restore operand"); // R2
   end
endmodule

// File: rtl/isa_lite_exec.sv
module isa_lite_exec
   import isa_lite_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int RIDX_W      = 5,
   parameter int UPPER_SHIFT = 16,
   parameter int SHIFT_STYLE = 1
) (
   input  logic [31:0]       instr,
   input  logic [XLEN-1:0]   rs1_val,
   input  logic [XLEN-1:0]   rs2_val,
   output logic [RIDX_W-1:0] rs1_idx,
   output logic [RIDX_W-1:0] rs2_idx,
   output logic [RIDX_W-1:0] rd_idx,
   output logic              rd_we,
   output logic [XLEN-1:0]   rd_data,
   output logic              illegal
);
   generate
      if (XLEN < 32 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
         $error("XLEN must be a power of two of at least 32");
      end
      if (RIDX_W != 5) begin : g_bad_ridx
         $error("register index fields are five bits wide");
      end
      if (UPPER_SHIFT < 0 || UPPER_SHIFT >= XLEN) begin : g_bad_upper
         $error("UPPER_SHIFT must lie inside the datapath");
      end
      if (SHIFT_STYLE != 0 && SHIFT_STYLE != 1) begin : g_bad_shift
         $error("SHIFT_STYLE selects 0 (operator) or 1 (staged)");
      end
   endgenerate

   logic [6:0]      opcode, funct7;
   logic [2:0]      funct3;
   logic [XLEN-1:0] imm_sext, imm_zext, imm_upper;
   logic [XLEN-1:0] opb_val, alu_y;
   alu_fn_e         fn;
   opb_sel_e        opb;
   logic            legal;

   ilx_fields #(.XLEN(XLEN), .RIDX_W(RIDX_W), .UPPER_SHIFT(UPPER_SHIFT)) u_fields (
      .instr    (instr),
      .rs1_idx  (rs1_idx),
      .rs2_idx  (rs2_idx),
      .rd_idx   (rd_idx),
      .opcode   (opcode),
      .funct3   (funct3),
      .funct7   (funct7),
      .imm_sext (imm_sext),
      .imm_zext (imm_zext),
      .imm_upper(imm_upper)
   );

   ilx_decode u_decode (
      .opcode(opcode),
      .funct3(funct3),
      .funct7(funct7),
      .fn    (fn),
      .opb   (opb),
      .legal (legal)
   );

   always_comb begin
      case (opb)
         OPB_SEXT:  opb_val = imm_sext;
         OPB_ZEXT:  opb_val = imm_zext;
         OPB_UPPER: opb_val = imm_upper;
         default:   opb_val = rs2_val;
      endcase
   end

   ilx_alu #(.XLEN(XLEN), .SHIFT_STYLE(SHIFT_STYLE)) u_alu (
      .a (rs1_val),
      .b (opb_val),
      .fn(fn),
      .y (alu_y)
   );

   assign illegal = ~legal;
   assign rd_we   = legal && (rd_idx != '0);
   assign rd_data = legal ? alu_y : '0;

   always_comb begin
      if (illegal)
         AST_ILLEGAL_NO_WRITE: assert (!rd_we && rd_data == '0)
            else $error("illegal instruction leaked a write"); // R9
      if (rd_idx == '0)
         AST_X0_NO_WRITE: assert (!rd_we)
            else $error("write strobe raised for register zero"); // R10
   end
endmodule

// File: tb/sim_isa_lite_exec.sv
module sim_isa_lite_exec;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr = 32'h0;
   logic [31:0] rs1_val = 32'h0;
   logic [31:0] rs2_val = 32'h0;
   logic [4:0]  rs1_idx, rs2_idx, rd_idx;
   logic        rd_we, illegal;
   logic [31:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [31:0] seed = 32'h1234_5678;

   always #5 clk = ~clk;

   isa_lite_exec u0 (
      .instr(instr), .rs1_val(rs1_val), .rs2_val(rs2_val),
      .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .rd_idx(rd_idx),
      .rd_we(rd_we), .rd_data(rd_data), .illegal(illegal)
   );

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   task automatic rnd(output logic [31:0] v);
      seed = nxt(seed);
      v = seed;
   endtask

   // Independent reference built from the requirement text.
   task automatic model(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b,
                        output logic ok, output logic [31:0] d, output string tag);
      logic [6:0] op = i[6:0];
      logic [2:0] f3 = i[14:12];
      logic [6:0] f7 = i[31:25];
      int sh = int'(b[4:0]);
      ok = 1'b0; d = 32'h0; tag = "R9";
      if (op == 7'h33) begin
         if (f3 == 3'd0 && f7 == 7'h00) begin ok = 1; d = a + b; tag = "R2"; end
         else if (f3 == 3'd0 && f7 == 7'h20) begin ok = 1; d = a + ~b + 32'd1; tag = "R2"; end
         else if (f3 == 3'd6 && f7 == 7'h00) begin ok = 1; d = a | b; tag = "R3"; end
         else if (f3 == 3'd4 && f7 == 7'h00) begin ok = 1; d = a ^ b; tag = "R3"; end
         else if (f3 == 3'd1 && f7 == 7'h00) begin
            ok = 1; tag = "R4"; d = a;
            for (int k = 0; k < sh; k++) d = {d[30:0], 1'b0};
         end else if (f3 == 3'd5 && (f7 == 7'h00 || f7 == 7'h20)) begin
            ok = 1; tag = "R5"; d = a;
            for (int k = 0; k < sh; k++) d = {(f7 == 7'h20) ? a[31] : 1'b0, d[31:1]};
         end
      end else if (op == 7'h13) begin
         if (f3 == 3'd0) begin ok = 1; d = a + {{20{i[31]}}, i[31:20]}; tag = "R6"; end
         else if (f3 == 3'd7) begin ok = 1; d = a & {20'h0, i[31:20]}; tag = "R7"; end
         else if (f3 == 3'd6) begin ok = 1; d = a | {20'h0, i[31:20]}; tag = "R7"; end
      end else if (op == 7'h37) begin
         ok = 1; d = {i[27:12], 16'h0000}; tag = "R8";
      end
   endtask

   task automatic fail_or_pass(input bit good, input string tag, input string what,
                               input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!good) begin
         errors++;
         $display("FAIL %s %s instr=%h act=%h exp=%h", tag, what, instr, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
      logic ok;
      logic [31:0] d;
      string tag;
      @(negedge clk);
      instr = i; rs1_val = a; rs2_val = b;
      #2;
      model(i, a, b, ok, d, tag);
      fail_or_pass(rd_data === d, tag, "rd_data", rd_data, d);
      fail_or_pass(illegal === !ok, ok ? tag : "R9", "illegal", {31'h0, illegal}, {31'h0, !ok});
      fail_or_pass(rd_we === (ok && i[11:7] != 5'd0), "R10", "rd_we",
                   {31'h0, rd_we}, {31'h0, ok && i[11:7] != 5'd0});
      fail_or_pass({rs1_idx, rs2_idx, rd_idx} === {i[19:15], i[24:20], i[11:7]}, "R1",
                   "indices", {17'h0, rs1_idx, rs2_idx, rd_idx}, {17'h0, i[19:15], i[24:20], i[11:7]});
   endtask

   function automatic logic [31:0] rtype(input logic [6:0] f7, input logic [2:0] f3, input logic [4:0] rd);
      return {f7, 5'd2, 5'd1, f3, rd, 7'h33};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired act=%0d exp=%0d", checks, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] a, b, r;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset-time pattern: all-zero word is an unsupported opcode (R9)
      apply(32'h0, 32'h0, 32'h0);

      // R1: random words, indices follow bit fields
      for (int n = 0; n < 200; n++) begin rnd(r); rnd(a); rnd(b); apply(r, a, b); end

      // R2, R3: arithmetic and logic over corner and random operands
      for (int n = 0; n < 60; n++) begin
         rnd(a); rnd(b);
         if (n == 0) begin a = 32'hFFFF_FFFF; b = 32'h1; end
         if (n == 1) begin a = 32'h0; b = 32'h1; end
         if (n == 2) begin a = 32'h8000_0000; b = 32'h8000_0000; end
         apply(rtype(7'h00, 3'd0, 5'd3), a, b);
         apply(rtype(7'h20, 3'd0, 5'd4), a, b);
         apply(rtype(7'h00, 3'd6, 5'd5), a, b);
         apply(rtype(7'h00, 3'd4, 5'd6), a, b);
      end

      // R4, R5: every shift amount, junk in the upper amount bits
      for (int s = 0; s < 32; s++) begin
         for (int v = 0; v < 4; v++) begin
            rnd(r);
            a = (v == 0) ? 32'h8000_0001 : (v == 1) ? 32'h7FFF_FFFF : (v == 2) ? 32'hF0F0_1234 : r;
            rnd(b);
            b = {b[31:5], 5'(s)};
            apply(rtype(7'h00, 3'd1, 5'd7), a, b);
            apply(rtype(7'h00, 3'd5, 5'd8), a, b);
            apply(rtype(7'h20, 3'd5, 5'd9), a, b);
         end
      end

      // R6, R7: every 12-bit immediate
      for (int im = 0; im < 4096; im++) begin
         rnd(a); rnd(b);
         apply({12'(im), 5'd3, 3'd0, 5'd10, 7'h13}, a, b);
         apply({12'(im), 5'd3, 3'd7, 5'd11, 7'h13}, a, b);
         apply({12'(im), 5'd3, 3'd6, 5'd12, 7'h13}, a, b);
      end

      // R8: upper immediate patterns, top field bits must vanish
      for (int n = 0; n < 1024; n++) begin
         rnd(r); rnd(a); rnd(b);
         if (n == 0) r = 32'hFFFF_F000;
         if (n == 1) r = 32'hF000_0000;
         apply({r[31:12], 5'd13, 7'h37}, a, b);
      end

      // R9: full opcode x funct3 sweep with several funct7 values
      for (int op = 0; op < 128; op++) begin
         for (int f3 = 0; f3 < 8; f3++) begin
            for (int k = 0; k < 4; k++) begin
               logic [6:0] f7;
               f7 = (k == 0) ? 7'h00 : (k == 1) ? 7'h20 : (k == 2) ? 7'h01 : 7'h7F;
               rnd(r); rnd(a); rnd(b);
               apply({f7, r[24:15], 3'(f3), r[11:7] | 5'd1, 7'(op)}, a, b);
            end
         end
      end

      // R10: destination zero keeps the result but never writes
      for (int n = 0; n < 20; n++) begin
         rnd(a); rnd(b);
         apply(rtype(7'h00, 3'd0, 5'd0), a, b);
         apply({12'(n * 97), 5'd1, 3'd6, 5'd0, 7'h13}, a, b);
         apply({a[31:12], 5'd0, 7'h37}, a, b);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule